// File: doc/BRIEF.md
# Exclusive Resource Ownership Register Bank

This block hands out exclusive ownership of shared resources to up to sixteen software agents. Each agent has one ownership word with one bit per resource. An agent claims resources by writing a mask to its "acquire" address. It gives them back by writing a mask to its "release" address. Reading either of its two addresses returns the agent's current ownership word.

A claim succeeds bit by bit. A bit is granted only when no other agent holds that resource. A claim that loses to another owner is dropped quietly, and software finds out by reading the word back. Two misuses raise a sticky error interrupt: claiming a resource the agent already holds, and releasing one it does not hold. A status word shows the interrupt flag and the number of the agent that caused the most recent misuse. Writing a 1 to bit 0 of the status word clears the flag.

The block sits on a plain synchronous register bus. There is one access per cycle and no back-pressure: a write takes effect at the clock edge where `wr_en` is high. Read data appears one cycle after `rd_en`.

Top module: `hw_lock_bank`

## Requirements
- R1: After reset every ownership bit is 0, `irq` is 0 and the status word reads 0.
- R2: Address bit 5 = 0 selects an agent word, with bits [4:1] giving the agent number. Bit 0 = 1 is the acquire address and bit 0 = 0 is the release address. A read of either address returns that agent's ownership word on `rd_data` in the cycle after `rd_en`. A read returns the state before any write accepted at the same edge.
- R3: A write to an agent's acquire address sets every bit of the write mask that no other agent owns.
- R4: A mask bit owned by another agent stays 0 in the writer's word. That agent's word is unchanged, and no error is raised.
- R5: An acquire write whose mask includes a bit the writer already owns sets `irq` on the next cycle. The owned bit stays owned.
- R6: A write to an agent's release address clears every mask bit in that agent's own word.
- R7: A release write whose mask includes a bit the writer does not own sets `irq` on the next cycle. The words of all other agents are never changed by an agent-word write.
- R8: At no time does more than one agent own the same resource.
- R9: `irq` stays high until a write to the status address (address bit 5 = 1) with data bit 0 = 1. A status write with data bit 0 = 0 leaves it set.
- R10: A status read returns the flag in bit 0 and the number of the most recently offending agent in bits [11:8]. All other bits are 0.
- R11: Within one write each mask bit is handled on its own. Legal bits take effect even when other bits in the same write are violations, and any number of violating bits raises a single error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| addr | input | 6 | Register address |
| wdata | input | 32 | Write data / resource mask |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| irq | output | 1 | Sticky protocol-error interrupt |

## Verification
Every write result is due at the first clock edge after the write. Ownership words, `irq` and the status word all change at that edge. Read data is due one edge after `rd_en` and reflects the state from before a write at that same edge. The bench's reference model therefore advances on each rising edge using the inputs it has just driven. The bench compares `irq` on every falling edge, and compares `rd_data` on the falling edge that follows each read, so every comparison lands exactly one register stage after its stimulus.

// File: rtl/hwl_pkg.sv
package hwl_pkg;
  // decoded bus operation
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_REL  = 2'd1,
    OP_ACQ  = 2'd2,
    OP_STAT = 2'd3
  } op_e;

  // position of the offending-agent field inside the status word
  localparam int unsigned STAT_AGENT_LSB = 8;
endpackage

// File: rtl/hwl_decode.sv
module hwl_decode #(
  parameter int unsigned AG_W   = 4,
  parameter int unsigned ADDR_W = AG_W + 2
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output hwl_pkg::op_e      op,
  output logic [AG_W-1:0]   agent
);
  import hwl_pkg::*;

  always_comb begin
    agent = addr[AG_W:1];
    if (!wr_en)                 op = OP_NONE;
    else if (addr[ADDR_W-1])    op = OP_STAT;
    else if (addr[0])           op = OP_ACQ;
    else                        op = OP_REL;
  end
endmodule

// File: rtl/hwl_owner_calc.sv
module hwl_owner_calc #(
  parameter int unsigned N_AGENTS = 16,
  parameter int unsigned N_RES    = 32,
  parameter int unsigned AG_W     = $clog2(N_AGENTS)
) (
  input  logic [N_AGENTS-1:0][N_RES-1:0] own_q,
  input  hwl_pkg::op_e                   op,
  input  logic [AG_W-1:0]                agent,
  input  logic [N_RES-1:0]               mask,
  output logic [N_AGENTS-1:0][N_RES-1:0] own_d,
  output logic                           proto_err
);
  import hwl_pkg::*;

  logic [N_RES-1:0] held_by_others;
  logic [N_RES-1:0] mine;

  // union of every other agent's word, taken from the pre-write state
  always_comb begin
    held_by_others = '0;
    for (int j = 0; j < N_AGENTS; j++) begin
      if (AG_W'(j) != agent) held_by_others |= own_q[j];
    end
  end

  assign mine = own_q[agent];

  assign proto_err = ((op == OP_ACQ) && |(mask & mine)) ||
                     ((op == OP_REL) && |(mask & ~mine));

  // each agent row only moves when it is the addressed one
  for (genvar g = 0; g < N_AGENTS; g++) begin : g_row
    logic hit;
    assign hit = (agent == AG_W'(g));
    always_comb begin
      own_d[g] = own_q[g];
      if (hit && op == OP_ACQ) own_d[g] = own_q[g] | (mask & ~held_by_others);
      if (hit && op == OP_REL) own_d[g] = own_q[g] & ~mask;
    end
  end
endmodule

// File: rtl/hwl_err_status.sv
module hwl_err_status #(
  parameter int unsigned AG_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            proto_err,
  input  logic [AG_W-1:0] agent,
  input  logic            flag_clr,
  output logic            flag_q,
  output logic [AG_W-1:0] last_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      last_q <= '0;
    end else if (proto_err) begin
      flag_q <= 1'b1;
      last_q <= agent;
    end else if (flag_clr) begin
      flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/hw_lock_bank.sv
module hw_lock_bank #(
  parameter int unsigned N_AGENTS = 16,
  parameter int unsigned N_RES    = 32,
  localparam int unsigned AG_W    = $clog2(N_AGENTS),
  localparam int unsigned ADDR_W  = AG_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_RES-1:0]  wdata,
  input  logic              rd_en,
  output logic [N_RES-1:0]  rd_data,
  output logic              irq
);
  import hwl_pkg::*;

  op_e                           op;
  logic [AG_W-1:0]               agent;
  logic [N_AGENTS-1:0][N_RES-1:0] own_q, own_d;
  logic                          proto_err;
  logic                          flag_q;
  logic [AG_W-1:0]               last_q;
  logic [N_RES-1:0]              stat_word;

  hwl_decode #(.AG_W(AG_W), .ADDR_W(ADDR_W)) u_dec (
    .wr_en (wr_en),
    .addr  (addr),
    .op    (op),
    .agent (agent)
  );

  hwl_owner_calc #(.N_AGENTS(N_AGENTS), .N_RES(N_RES), .AG_W(AG_W)) u_calc (
    .own_q     (own_q),
    .op        (op),
    .agent     (agent),
    .mask      (wdata),
    .own_d     (own_d),
    .proto_err (proto_err)
  );

  hwl_err_status #(.AG_W(AG_W)) u_err (
    .clk       (clk),
    .rst_n     (rst_n),
    .proto_err (proto_err),
    .agent     (agent),
    .flag_clr  ((op == OP_STAT) && wdata[0]),
    .flag_q    (flag_q),
    .last_q    (last_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_q <= '0;
    else        own_q <= own_d;
  end

  always_comb begin
    stat_word = '0;
    stat_word[0] = flag_q;
    stat_word[STAT_AGENT_LSB +: AG_W] = last_q;
  end

  // read returns pre-write state, one cycle after the strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rd_data <= '0;
    else if (rd_en)    rd_data <= addr[ADDR_W-1] ? stat_word : own_q[addr[AG_W:1]];
  end

  assign irq = flag_q;
endmodule

// File: rtl/hwl_lock_chk.sv
module hwl_lock_chk #(
  parameter int unsigned N_AGENTS = 16,
  parameter int unsigned N_RES    = 32,
  localparam int unsigned AG_W    = $clog2(N_AGENTS),
  localparam int unsigned ADDR_W  = AG_W + 2
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           wr_en,
  input logic [ADDR_W-1:0]              addr,
  input logic [N_RES-1:0]               wdata,
  input logic                           irq,
  input logic [N_AGENTS-1:0][N_RES-1:0] own_q
);
  logic [N_RES-1:0][N_AGENTS-1:0] cols;
  logic             agent_wr, acq_wr, rel_wr, dup, bad;
  logic             prev_rel;
  logic [AG_W-1:0]  prev_agent;
  logic [N_RES-1:0] prev_mask;

  always_comb begin
    for (int r = 0; r < N_RES; r++)
      for (int a = 0; a < N_AGENTS; a++)
        cols[r][a] = own_q[a][r];
  end

  assign agent_wr = wr_en && !addr[ADDR_W-1];
  assign acq_wr   = agent_wr && addr[0];
  assign rel_wr   = agent_wr && !addr[0];
  assign dup      = acq_wr && |(wdata & own_q[addr[AG_W:1]]);
  assign bad      = rel_wr && |(wdata & ~own_q[addr[AG_W:1]]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_rel   <= 1'b0;
      prev_agent <= '0;
      prev_mask  <= '0;
    end else begin
      prev_rel   <= rel_wr;
      prev_agent <= addr[AG_W:1];
      prev_mask  <= wdata;
    end
  end

  // R8: each resource has at most one owner
  for (genvar r = 0; r < N_RES; r++) begin : g_res
    p_single_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cols[r]));
  end

  // R7 (and R4): a write never alters another agent's word
  for (genvar a = 0; a < N_AGENTS; a++) begin : g_ag
    p_others_untouched_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!(agent_wr && addr[AG_W:1] == AG_W'(a))) |=> $stable(own_q[a]));
  end

  p_dup_acquire_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dup |=> irq);

  p_bad_release_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> irq);

  // R4: lost or legal requests leave the flag low
  p_quiet_when_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !dup && !bad) |=> !irq);

  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr_en && addr[ADDR_W-1] && wdata[0])) |=> irq);

  // R6: released bits are gone one cycle later
  p_release_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prev_rel |-> ((own_q[prev_agent] & prev_mask) == '0));
endmodule

bind hw_lock_bank hwl_lock_chk #(.N_AGENTS(N_AGENTS), .N_RES(N_RES)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .wr_en (wr_en),
  .addr  (addr),
  .wdata (wdata),
  .irq   (irq),
  .own_q (own_q)
);

// File: tb/sim_hw_lock_bank.sv
`timescale 1ns/1ps
module sim_hw_lock_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model
  logic [31:0] m_own [16];
  bit          m_irq;
  logic [3:0]  m_last;
  logic [31:0] m_rd;
  bit          m_rd_pend;
  bit          live = 0;

  always #4 clk = ~clk;

  hw_lock_bank u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                   .wdata(wdata), .rd_en(rd_en), .rd_data(rd_data), .irq(irq));

  function automatic logic [5:0] acq_a(input int k); return {1'b0, 4'(k), 1'b1}; endfunction
  function automatic logic [5:0] rel_a(input int k); return {1'b0, 4'(k), 1'b0}; endfunction
  localparam logic [5:0] STAT_A = 6'h20;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_own[i]) m_own[i] = '0;
      m_irq = 0; m_last = '0; m_rd_pend = 0; m_rd = '0;
    end else begin
      m_rd_pend = rd_en;
      if (rd_en) m_rd = addr[5] ? {20'b0, m_last, 7'b0, m_irq} : m_own[addr[4:1]];
      if (wr_en) begin
        int k;
        logic [31:0] others, badm;
        k = int'(addr[4:1]);
        if (addr[5]) begin
          if (wdata[0]) m_irq = 0;
        end else begin
          others = '0;
          for (int j = 0; j < 16; j++) if (j != k) others |= m_own[j];
          if (addr[0]) begin
            badm = wdata & m_own[k];
            m_own[k] = m_own[k] | (wdata & ~others);
          end else begin
            badm = wdata & ~m_own[k];
            m_own[k] = m_own[k] & ~wdata;
          end
          if (badm != 0) begin m_irq = 1; m_last = 4'(k); end
        end
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      checks++;
      if (irq !== 1'b0) begin
        errors++;
        $display("FAIL R1 irq during reset actual=%0b expected=0", irq);
      end
    end else if (live) begin
      checks++;
      if (irq !== m_irq) begin
        errors++;
        $display("FAIL %s irq actual=%0b expected=%0b", cur_req, irq, m_irq);
      end
      if (m_rd_pend) begin
        checks++;
        if (rd_data !== m_rd) begin
          errors++;
          $display("FAIL %s rd_data actual=%08h expected=%08h", cur_req, rd_data, m_rd);
        end
      end
    end
  end

  task automatic bus(input bit we, input bit re, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = we; rd_en = re; addr = a; wdata = d;
  endtask
  task automatic wr(input logic [5:0] a, input logic [31:0] d); bus(1, 0, a, d); endtask
  task automatic rd(input logic [5:0] a); bus(0, 1, a, '0); endtask
  task automatic idle(); bus(0, 0, '0, '0); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    live = 1;
    // R1: reset state via reads
    cur_req = "R1";
    rd(acq_a(0)); rd(rel_a(5)); rd(acq_a(15)); rd(STAT_A);
    // R3 / R2: grant free bits, read back from both addresses
    cur_req = "R3";
    wr(acq_a(2), 32'h0000_00F0);
    cur_req = "R2";
    rd(acq_a(2)); rd(rel_a(2));
    // R4: contention silently lost
    cur_req = "R4";
    wr(acq_a(7), 32'h0000_0FF0);
    rd(acq_a(7)); rd(rel_a(2)); idle();
    // R5: duplicate acquire
    cur_req = "R5";
    wr(acq_a(2), 32'h0000_0010);
    rd(acq_a(2));
    cur_req = "R10";
    rd(STAT_A);
    // R9: W1C behaviour
    cur_req = "R9";
    wr(STAT_A, 32'h0000_0000); idle(); wr(STAT_A, 32'h0000_0001);
    rd(STAT_A); idle();
    // R6: release own bits
    cur_req = "R6";
    wr(rel_a(2), 32'h0000_0030);
    rd(acq_a(2)); rd(acq_a(7));
    // R7: release of unowned bit
    cur_req = "R7";
    wr(rel_a(7), 32'h0000_0001);
    rd(rel_a(7)); rd(rel_a(2)); rd(STAT_A);
    wr(STAT_A, 32'h1);
    // R11: mixed masks
    cur_req = "R11";
    wr(acq_a(15), 32'hFFFF_FFFF);
    rd(acq_a(15)); rd(STAT_A);
    wr(acq_a(15), 32'h8000_0100);
    rd(acq_a(15)); rd(STAT_A);
    wr(STAT_A, 32'h1);
    wr(rel_a(15), 32'h0000_0101);
    rd(acq_a(15)); rd(STAT_A);
    wr(STAT_A, 32'h1);
    // R8: contention soak across a few agents
    cur_req = "R8";
    for (int n = 0; n < 600; n++) begin
      int sel, k;
      sel = $urandom_range(0, 9);
      k = $urandom_range(0, 3);
      if (sel < 3)       wr(acq_a(k), $urandom & $urandom);
      else if (sel < 6)  wr(rel_a(k), $urandom & $urandom & $urandom);
      else if (sel < 8)  rd($urandom_range(0, 1) ? acq_a(k) : rel_a(k));
      else if (sel == 8) rd(STAT_A);
      else               wr(STAT_A, {31'b0, 1'($urandom_range(0, 1))});
    end
    idle(); idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule